// File: doc/BRIEF.md
# Interrupt Acceptance Gate

This block decides, cycle by cycle, whether a pipelined core may take a new external interrupt. Three kinds of operation can alter the core's master interrupt-enable flag: an enable instruction, a disable instruction, and the delivery of an interrupt. The gate keeps a count of how many of these operations have passed decode but have not yet retired. An interrupt is taken only when that count is zero and the architectural flag is set. Checking the enable bit alone is not enough, because an older operation still in the pipeline could change the flag after the interrupt is taken.

When the gate accepts an interrupt, it raises an acknowledge pulse. In that same cycle it injects the interrupt into the decode slot and asks for a light purge of the fetch buffer. The injected delivery counts as an in-flight flag-changing operation. The flag itself changes only when an operation retires. A pipeline flush reports how many flag-changing operations it discarded, and the count drops by that amount. Exceptions have no input here and cannot touch the flag.

Top module: `irq_accept_gate`

## Requirements
- R1: After reset the enable flag equals the parameter `IEN_RESET` (default 0), the in-flight count is zero, and no acknowledge, inject or purge strobe is high.
- R2: The flag changes only at retire. A retired enable instruction sets it to 1. A retired disable instruction or a retired interrupt delivery clears it to 0, and a clear wins over a set in the same cycle. With no retire strobe the flag holds its value.
- R3: The in-flight count rises by one for each flag-changing operation that decode accepts (an enable or disable instruction that is not stalled, or an injected interrupt). It falls by one for each retire strobe.
- R4: If an increment and a single retire occur in the same cycle, the count is unchanged.
- R5: On a flush, the count is reduced by `flush_squashed_i` in addition to any retires, and it stops at zero instead of going below.
- R6: The acknowledge is high only when the request is high, the count is zero and the flag is 1. Otherwise the request stays pending and nothing is taken.
- R7: An acknowledge lasts one cycle. Inject and fetch purge are high in exactly the cycles where the acknowledge is high.
- R8: In a cycle with an acknowledge, decode is stalled, because the injected interrupt occupies the decode slot.
- R9: When the count equals 2^CNT_W−1, decode is stalled and a flag-changing operation offered at decode does not raise the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_ien_set_i | input | 1 | Enable instruction present at decode |
| dec_ien_clr_i | input | 1 | Disable instruction present at decode |
| ret_ien_set_i | input | 1 | Enable instruction retires |
| ret_ien_clr_i | input | 1 | Disable instruction retires |
| ret_irq_dlv_i | input | 1 | Interrupt delivery retires |
| flush_i | input | 1 | Pipeline flush this cycle |
| flush_squashed_i | input | CNT_W | Number of flag-changing operations discarded by the flush |
| irq_req_i | input | 1 | Pending external interrupt request, held until acknowledged |
| irq_ack_o | output | 1 | Interrupt accepted (single-cycle pulse) |
| inject_o | output | 1 | Inject interrupt into decode this cycle |
| fetch_purge_o | output | 1 | Light purge of the fetch buffer |
| dec_stall_o | output | 1 | Decode must hold its flag-changing operation |
| ien_o | output | 1 | Architectural interrupt-enable flag |

## Verification
The bench targets the windows in which the flag is already 1 but older flag-changing operations are still in flight. A gate that only looked at the enable bit would acknowledge too early, and the bench would see that as a spurious pulse. It also drives an increment and a retire in the same cycle, where a wrong priority would leave the count off by one and hold back a later acknowledge. It drives flushes that discard more operations than are counted; a count that wrapped below zero would block interrupts for good. Finally, it fills the count to its limit, where a gate without the stall would wrap the count and then accept an interrupt it should have refused.

// File: rtl/gate_pkg.sv
package gate_pkg;

  // retire-side flag action
  typedef enum logic [1:0] {
    IEN_HOLD = 2'd0,
    IEN_SET  = 2'd1,
    IEN_CLR  = 2'd2
  } ien_action_e;

  // number of retire strobes active in one cycle
  function automatic logic [1:0] gate_ret_count(input logic a, input logic b, input logic c);
    return {1'b0, a} + {1'b0, b} + {1'b0, c};
  endfunction

  // next in-flight count: add, subtract, floor at zero, cap at limit
  function automatic int unsigned gate_next_count(input int unsigned cur,
                                                  input int unsigned up,
                                                  input int unsigned down,
                                                  input int unsigned limit);
    int unsigned sum;
    sum = cur + up;
    if (down >= sum) return 0;
    if ((sum - down) > limit) return limit;
    return sum - down;
  endfunction

  // retire-side action: a clear beats a set
  function automatic ien_action_e gate_ien_action(input logic set_r, input logic clr_r, input logic dlv_r);
    if (clr_r || dlv_r) return IEN_CLR;
    if (set_r) return IEN_SET;
    return IEN_HOLD;
  endfunction

endpackage

// File: rtl/gate_ien_reg.sv
module gate_ien_reg
  import gate_pkg::*;
#(
  parameter logic IEN_RESET = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ret_set_i,
  input  logic        ret_clr_i,
  input  logic        ret_dlv_i,
  output ien_action_e action_o,
  output logic        ien_o
);

  logic ien_q;

  assign action_o = gate_ien_action(ret_set_i, ret_clr_i, ret_dlv_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ien_q <= IEN_RESET;
    end else begin
      unique case (action_o)
        IEN_SET:  ien_q <= 1'b1;
        IEN_CLR:  ien_q <= 1'b0;
        default:  ien_q <= ien_q;
      endcase
    end
  end

  assign ien_o = ien_q;

endmodule

// File: rtl/gate_inflight.sv
module gate_inflight
  import gate_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  input  logic [1:0]       ret_n_i,
  input  logic             flush_i,
  input  logic [CNT_W-1:0] flush_cnt_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_o,
  output logic             full_o
);

  localparam int unsigned LIMIT = (1 << CNT_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  int unsigned      down_w;

  always_comb begin
    down_w = 32'(ret_n_i);
    if (flush_i) down_w = down_w + 32'(flush_cnt_i);
    cnt_d = CNT_W'(gate_next_count(32'(cnt_q), 32'(inc_i), down_w, LIMIT));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);
  assign full_o = (cnt_q == CNT_W'(LIMIT));

endmodule

// File: rtl/gate_accept.sv
module gate_accept (
  input  logic irq_req_i,
  input  logic zero_i,
  input  logic ien_i,
  input  logic full_i,
  input  logic dec_op_i,
  output logic ack_o,
  output logic stall_o,
  output logic dec_take_o,
  output logic inc_o
);

  always_comb begin
    ack_o      = irq_req_i && zero_i && ien_i;
    stall_o    = full_i || ack_o;
    dec_take_o = dec_op_i && !stall_o;
    inc_o      = dec_take_o || ack_o;
  end

endmodule

// File: rtl/irq_accept_gate.sv
module irq_accept_gate
  import gate_pkg::*;
#(
  parameter int   CNT_W     = 8,
  parameter logic IEN_RESET = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dec_ien_set_i,
  input  logic             dec_ien_clr_i,
  input  logic             ret_ien_set_i,
  input  logic             ret_ien_clr_i,
  input  logic             ret_irq_dlv_i,
  input  logic             flush_i,
  input  logic [CNT_W-1:0] flush_squashed_i,
  input  logic             irq_req_i,
  output logic             irq_ack_o,
  output logic             inject_o,
  output logic             fetch_purge_o,
  output logic             dec_stall_o,
  output logic             ien_o
);

  // named internal events
  logic             dec_op_w;
  logic             dec_take_w;
  logic             inc_w;
  logic [1:0]       ret_n_w;
  logic [CNT_W-1:0] inflight_q;
  logic             zero_w;
  logic             full_w;
  logic             ack_w;
  logic             stall_w;
  ien_action_e      ien_act_w;

  assign dec_op_w = dec_ien_set_i || dec_ien_clr_i;
  assign ret_n_w  = gate_ret_count(ret_ien_set_i, ret_ien_clr_i, ret_irq_dlv_i);

  gate_ien_reg #(.IEN_RESET(IEN_RESET)) u_ien (
    .clk       (clk),
    .rst_n     (rst_n),
    .ret_set_i (ret_ien_set_i),
    .ret_clr_i (ret_ien_clr_i),
    .ret_dlv_i (ret_irq_dlv_i),
    .action_o  (ien_act_w),
    .ien_o     (ien_o)
  );

  gate_inflight #(.CNT_W(CNT_W)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .inc_i       (inc_w),
    .ret_n_i     (ret_n_w),
    .flush_i     (flush_i),
    .flush_cnt_i (flush_squashed_i),
    .cnt_o       (inflight_q),
    .zero_o      (zero_w),
    .full_o      (full_w)
  );

  gate_accept u_acc (
    .irq_req_i  (irq_req_i),
    .zero_i     (zero_w),
    .ien_i      (ien_o),
    .full_i     (full_w),
    .dec_op_i   (dec_op_w),
    .ack_o      (ack_w),
    .stall_o    (stall_w),
    .dec_take_o (dec_take_w),
    .inc_o      (inc_w)
  );

  assign irq_ack_o     = ack_w;
  assign inject_o      = ack_w;
  assign fetch_purge_o = ack_w;
  assign dec_stall_o   = stall_w;

endmodule

// File: rtl/gate_checker.sv
module gate_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq_ack,
  input logic             inject,
  input logic             purge,
  input logic             stall,
  input logic             ien,
  input logic             dec_op,
  input logic             ret_set,
  input logic             ret_clr,
  input logic             ret_dlv,
  input logic             flush,
  input logic [CNT_W-1:0] flush_cnt,
  input logic [CNT_W-1:0] inflight,
  input logic             inc,
  input logic [1:0]       ret_n
);

  localparam logic [CNT_W-1:0] LIMIT = '1;

  logic [CNT_W+1:0] down_sum;
  logic [CNT_W+1:0] up_sum;
  assign down_sum = (CNT_W+2)'(flush_cnt) + (CNT_W+2)'(ret_n);
  assign up_sum   = (CNT_W+2)'(inflight) + (CNT_W+2)'(inc);

  assert_strobes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> (inject && purge));

  assert_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && ret_n == 2'd0 && !flush) |=> !irq_ack);

  assert_flag_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ien |-> !irq_ack);

  assert_busy_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (inflight != '0) |-> !irq_ack);

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && ret_n == 2'd1 && !flush) |=> $stable(inflight));

  assert_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && down_sum >= up_sum) |=> (inflight == '0));

  assert_ien_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_set && !ret_clr && !ret_dlv) |=> ien);

  assert_ien_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_clr || ret_dlv) |=> !ien);

  assert_inject_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> stall);

  assert_full_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (inflight == LIMIT && dec_op) |-> stall);

  assert_no_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (inflight == LIMIT && ret_n == 2'd0 && !flush) |=> (inflight == LIMIT));

endmodule

bind irq_accept_gate gate_checker #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_ack   (irq_ack_o),
  .inject    (inject_o),
  .purge     (fetch_purge_o),
  .stall     (dec_stall_o),
  .ien       (ien_o),
  .dec_op    (dec_op_w),
  .ret_set   (ret_ien_set_i),
  .ret_clr   (ret_ien_clr_i),
  .ret_dlv   (ret_irq_dlv_i),
  .flush     (flush_i),
  .flush_cnt (flush_squashed_i),
  .inflight  (inflight_q),
  .inc       (inc_w),
  .ret_n     (ret_n_w)
);

// File: tb/sim_irq_accept_gate.sv
`timescale 1ns/1ps
module sim_irq_accept_gate;

  localparam int W   = 3;
  localparam int MAX = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic d_set = 0, d_clr = 0, r_set = 0, r_clr = 0, r_dlv = 0, fl = 0, req = 0;
  logic [W-1:0] fcnt = '0;
  logic ack, inj, prg, stl, ien;

  always #5 clk = ~clk;

  irq_accept_gate #(.CNT_W(W), .IEN_RESET(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n),
    .dec_ien_set_i(d_set), .dec_ien_clr_i(d_clr),
    .ret_ien_set_i(r_set), .ret_ien_clr_i(r_clr), .ret_irq_dlv_i(r_dlv),
    .flush_i(fl), .flush_squashed_i(fcnt), .irq_req_i(req),
    .irq_ack_o(ack), .inject_o(inj), .fetch_purge_o(prg),
    .dec_stall_o(stl), .ien_o(ien)
  );

  int checks = 0, fails = 0;
  int m_cnt = 0;
  logic m_ien = 1'b0;
  logic o_ack, o_stl, o_ien;
  bit finished = 0;

  task automatic chk(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b", what, act, exp);
    end
  endtask

  // one cycle: drive, compare against the arithmetic model, advance the model
  task automatic step(input logic ds, input logic dc, input logic rs, input logic rc,
                      input logic rd, input logic f, input int fc, input logic rq);
    logic e_ack, e_stl;
    int up, down, nxt;
    @(negedge clk);
    d_set = ds; d_clr = dc; r_set = rs; r_clr = rc; r_dlv = rd;
    fl = f; fcnt = W'(fc); req = rq;
    #2;
    e_ack = rq && (m_cnt == 0) && m_ien;
    e_stl = (m_cnt == MAX) || e_ack;
    o_ack = ack; o_stl = stl; o_ien = ien;
    chk(ack, e_ack, "R6 acknowledge");
    chk(inj, e_ack, "R7 inject");
    chk(prg, e_ack, "R7 purge");
    chk(stl, e_stl, e_ack ? "R8 stall on inject" : "R9 stall");
    chk(ien, m_ien, "R2 enable flag");
    @(posedge clk);
    up   = (((ds || dc) && !e_stl) ? 1 : 0) + (e_ack ? 1 : 0);
    down = int'(rs) + int'(rc) + int'(rd) + (f ? fc : 0);
    nxt  = m_cnt + up - down;
    if (nxt < 0) nxt = 0;
    if (nxt > MAX) nxt = MAX;
    m_cnt = nxt;
    if (rc || rd) m_ien = 1'b0;
    else if (rs) m_ien = 1'b1;
  endtask

  task automatic idle(input logic rq);
    step(0, 0, 0, 0, 0, 0, 0, rq);
  endtask

  // take an enable through decode and retire so the flag is 1 and count is 0
  task automatic arm();
    step(1, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0, 0, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    idle(0);
    chk(o_ien, 1'b0, "R1 flag after reset");
    chk(o_ack, 1'b0, "R1 no ack after reset");
    chk(o_stl, 1'b0, "R1 no stall after reset");
    idle(1);
    chk(o_ack, 1'b0, "R6 flag clear blocks request");

    // basic accept
    arm();
    idle(1);
    chk(o_ack, 1'b1, "R6 accept with count zero and flag set");
    chk(o_stl, 1'b1, "R8 decode stalled in inject cycle");
    idle(1);
    chk(o_ack, 1'b0, "R7 single-cycle acknowledge");
    step(0, 0, 0, 0, 1, 0, 0, 1);
    idle(1);
    chk(o_ien, 1'b0, "R2 delivery retire clears flag");
    chk(o_ack, 1'b0, "R6 no accept after delivery");

    // R3: count tracks decode and retire
    arm();
    step(1, 0, 0, 0, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0, 0, 0);
    idle(1);
    chk(o_ack, 1'b0, "R3 one operation still in flight");
    step(0, 0, 1, 0, 0, 0, 0, 1);
    chk(o_ack, 1'b0, "R3 retire cycle still counted");
    idle(1);
    chk(o_ack, 1'b1, "R3 accept after last retire");
    step(0, 0, 0, 0, 1, 0, 0, 0);
    arm();

    // R4: simultaneous increment and retire
    step(1, 0, 0, 0, 0, 0, 0, 0);
    step(1, 0, 1, 0, 0, 0, 0, 0);
    idle(1);
    chk(o_ack, 1'b0, "R4 count unchanged by inc plus retire");
    step(0, 0, 1, 0, 0, 0, 0, 0);
    idle(1);
    chk(o_ack, 1'b1, "R4 accept after final retire");
    step(0, 0, 0, 0, 1, 0, 0, 0);
    arm();

    // R5: flush larger than count floors at zero
    step(1, 0, 0, 0, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1, 5, 0);
    idle(1);
    chk(o_ack, 1'b1, "R5 flush floors count at zero");
    step(0, 0, 0, 0, 0, 1, 1, 0);
    idle(1);
    chk(o_ack, 1'b1, "R5 squashed delivery frees gate");
    step(0, 0, 0, 0, 0, 1, 1, 0);

    // R9: saturation stall
    for (int i = 0; i < MAX; i++) step(0, 1, 0, 0, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0, 0, 0);
    chk(o_stl, 1'b1, "R9 stall at count limit");
    step(0, 0, 0, 0, 0, 1, MAX - 1, 0);
    idle(1);
    chk(o_ack, 1'b0, "R9 no wrap: one still in flight");
    step(0, 0, 0, 0, 0, 1, 1, 0);
    idle(1);
    chk(o_ack, 1'b1, "R9 count drained to zero");
    step(0, 0, 0, 0, 0, 1, 1, 0);

    // near-exhaustive sweep against the model
    for (int n = 0; n < 20000; n++) begin
      logic ds, dc, rs, rc, rd, f, rq;
      int fc, k;
      ds = ($urandom % 4) == 0;
      dc = !ds && (($urandom % 8) == 0);
      rs = 0; rc = 0; rd = 0;
      if (m_cnt > 0 && ($urandom % 3) == 0) begin
        k = $urandom % 4;
        if (k < 2) rs = 1; else if (k == 2) rc = 1; else rd = 1;
      end
      f  = ($urandom % 40) == 0;
      fc = f ? int'($urandom % (m_cnt + 2)) : 0;
      if (fc > MAX) fc = MAX;
      rq = ($urandom % 2) == 0;
      step(ds, dc, rs, rc, rd, f, fc, rq);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule